// File: doc/BRIEF.md
# Hypercube Matrix Transposer

This block transposes a square matrix of side n = 2^q. The matrix is spread one element per cell over n*n cells, and the cells are wired as a hypercube. The cell index is formed with the row in the upper q bits and the column in the lower q bits. Each cell keeps a working register and a staging register. The staging register is used only while a run is in progress, and its contents at load time do not matter.

The host fills the cells through a write port while the block is idle. It then pulses `start`. The controller runs q iterations. The iteration bit index falls from 2q-1 down to q, and each iteration has two single-cycle exchange steps:

- **First step.** Every cell whose row bit and matching column bit differ copies its working value into the staging register of the neighbour across the row bit.
- **Second step.** Every cell whose two bits agree copies its staging value into the working register of the neighbour across the column bit.

The first iteration swaps the upper-right and lower-left quadrants. Each later iteration repeats that swap inside smaller sub-blocks. After `done`, the host reads the transposed matrix through a combinational read port.

Top module: `hcube_transposer`

## Requirements
- R1: After reset, `busy` and `done` are both 0 and every working register holds 0.
- R2: The cell address is row*n + col, with the row in address bits [2q-1:q] and the column in bits [q-1:0]. While idle, a write stores `wr_data` into the addressed cell. `rd_data` shows the working register selected by `rd_addr` in the same cycle. Working registers do not change in any idle cycle without a write.
- R3: A `start` sampled while idle raises `busy` at that edge. `done` is then high for exactly one cycle, 2q clock edges after the start edge, and `busy` falls at the same edge that raises `done`.
- R4: After a run, address j*n + i holds the value that was loaded at address i*n + j, for all i and j. For the 4x4 matrix with rows abcd/efgh/ijkl/mnop, the result has rows aeim/bfjn/cgko/dhlp. Diagonal cells never change during a run.
- R5: While `busy` is high, `wr_en` and `start` are ignored. The result and the timing of `done` are the same as in a run without them.
- R6: Starting a second run on a transposed matrix, with no reload in between, gives back the original matrix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load enable, honoured only while idle |
| wr_addr | input | 2q | Cell address to load (row*n + col) |
| wr_data | input | W | Element value to load |
| start | input | 1 | Begin a transposition, honoured only while idle |
| rd_addr | input | 2q | Cell address to read |
| rd_data | output | W | Working register of the addressed cell |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the run completes |

## Verification
The checker enforces these on every cycle:

- `done` is a single-cycle pulse that ends `busy` exactly 2q busy cycles after the run began.
- Diagonal cells hold their value through a run.
- Working registers stay put in idle cycles without a write.

Whether the off-diagonal values actually land in their mirrored cells, whether a repeated run restores the input, and whether writes and starts issued mid-run are dropped can only be shown by the bench. It loads several value patterns, including the lettered 4x4 case, and compares every cell against the index-swapped input.

// File: rtl/hct_pkg.sv
package hct_pkg;
   typedef enum logic {
      PH_SEND_OUT = 1'b0,
      PH_SEND_IN  = 1'b1
   } hct_phase_e;
endpackage

// File: rtl/hct_ctrl.sv
module hct_ctrl
   import hct_pkg::*;
#(
   parameter int Q   = 2,
   parameter int M_W = $clog2(2 * Q)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   output logic           busy,
   output logic           done,
   output logic           step_out,
   output logic           step_in,
   output logic [M_W-1:0] m_cur
);
   localparam logic [M_W-1:0] M_FIRST = M_W'(2 * Q - 1);
   localparam logic [M_W-1:0] M_LAST  = M_W'(Q);

   hct_phase_e phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         phase <= PH_SEND_OUT;
         m_cur <= M_FIRST;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               phase <= PH_SEND_OUT;
               m_cur <= M_FIRST;
            end
         end else if (phase == PH_SEND_OUT) begin
            phase <= PH_SEND_IN;
         end else if (m_cur == M_LAST) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            phase <= PH_SEND_OUT;
         end else begin
            m_cur <= m_cur - 1'b1;
            phase <= PH_SEND_OUT;
         end
      end
   end

   assign step_out = busy && (phase == PH_SEND_OUT);
   assign step_in  = busy && (phase == PH_SEND_IN);
endmodule

// File: rtl/hct_cell.sv
module hct_cell #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         take_b,
   input  logic [W-1:0] b_src,
   input  logic         take_a,
   input  logic [W-1:0] a_src,
   output logic [W-1:0] a_q,
   output logic [W-1:0] b_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         if (load_en) a_q <= load_val;
         else if (take_a) a_q <= a_src;
         if (take_b) b_q <= b_src;
      end
   end
endmodule

// File: rtl/hcube_transposer.sv
module hcube_transposer #(
   parameter int Q = 2,
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [2*Q-1:0] wr_addr,
   input  logic [W-1:0]   wr_data,
   input  logic           start,
   input  logic [2*Q-1:0] rd_addr,
   output logic [W-1:0]   rd_data,
   output logic           busy,
   output logic           done
);
   localparam int IDX_W = 2 * Q;
   localparam int N     = 1 << IDX_W;
   localparam int M_W   = $clog2(2 * Q);

   if (Q < 1) begin : g_bad_q
      $error("hcube_transposer: Q must be at least 1");
   end
   if (W < 1) begin : g_bad_w
      $error("hcube_transposer: W must be at least 1");
   end

   logic             step_out, step_in;
   logic [M_W-1:0]   m_cur, m_lo;
   logic [W-1:0]     a_arr [N];
   logic [W-1:0]     b_arr [N];
   logic [N*W-1:0]   a_flat;

   hct_ctrl #(.Q(Q), .M_W(M_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .busy    (busy),
      .done    (done),
      .step_out(step_out),
      .step_in (step_in),
      .m_cur   (m_cur)
   );

   assign m_lo = m_cur - M_W'(Q);

   for (genvar u = 0; u < N; u++) begin : g_cell
      localparam logic [IDX_W-1:0] U = IDX_W'(u);
      logic             same;
      logic [IDX_W-1:0] nb_hi, nb_lo;
      logic             load_hit;

      assign same     = (U[m_cur] == U[m_lo]);
      assign nb_hi    = U ^ (IDX_W'(1) << m_cur);
      assign nb_lo    = U ^ (IDX_W'(1) << m_lo);
      assign load_hit = wr_en && !busy && (wr_addr == U);

      hct_cell #(.W(W)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_en (load_hit),
         .load_val(wr_data),
         .take_b  (step_out && same),
         .b_src   (a_arr[nb_hi]),
         .take_a  (step_in && !same),
         .a_src   (b_arr[nb_lo]),
         .a_q     (a_arr[u]),
         .b_q     (b_arr[u])
      );

      assign a_flat[u*W +: W] = a_arr[u];
   end

   assign rd_data = a_arr[rd_addr];
endmodule

// File: rtl/hct_checker.sv
module hct_checker #(
   parameter int Q = 2,
   parameter int W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic                     busy,
   input logic                     done,
   input logic [(1<<(2*Q))*W-1:0]  a_flat
);
   localparam int NS    = 1 << Q;
   localparam int CNT_W = $clog2(2 * Q + 2) + 1;

   logic [NS*W-1:0] diag;
   logic [CNT_W-1:0] run_cnt;

   for (genvar i = 0; i < NS; i++) begin : g_diag
      assign diag[i*W +: W] = a_flat[(i*NS + i)*W +: W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else run_cnt <= '0;
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      $past(!rst_n) && rst_n |-> !busy && !done); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!busy && !wr_en) |-> a_flat == $past(a_flat)); // R2

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R3

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy)); // R3

   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> run_cnt == CNT_W'(2 * Q)); // R3

   AST_DIAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> diag == $past(diag)); // R4
endmodule

bind hcube_transposer hct_checker #(.Q(Q), .W(W)) u_hct_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .busy  (busy),
   .done  (done),
   .a_flat(a_flat)
);

// File: tb/hcube_transposer_bench.sv
module hcube_transposer_bench;
   localparam int Q  = 2;
   localparam int W  = 16;
   localparam int NS = 1 << Q;
   localparam int N  = NS * NS;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [2*Q-1:0] wr_addr = '0;
   logic [W-1:0]   wr_data = '0;
   logic           start = 1'b0;
   logic [2*Q-1:0] rd_addr = '0;
   logic [W-1:0]   rd_data;
   logic           busy, done;

   int n_checks = 0;
   int n_fail   = 0;
   logic [W-1:0] orig [N];

   always #10 clk = ~clk;

   hcube_transposer #(.Q(Q), .W(W)) u_hcube_transposer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy), .done(done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load_all();
      for (int k = 0; k < N; k++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = (2*Q)'(k); wr_data = orig[k];
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // expect_t=1: cell r*n+c holds orig[c*n+r]; else cell holds orig itself
   task automatic read_all(input string tag, input bit expect_t);
      for (int k = 0; k < N; k++) begin
         int r, c, src;
         r = k >> Q; c = k & (NS - 1);
         src = expect_t ? (c * NS + r) : k;
         rd_addr = (2*Q)'(k);
         #1;
         chk(tag, int'(rd_data), int'(orig[src]));
      end
   endtask

   task automatic run(input bit intrude);
      int cyc;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R3 busy raised", int'(busy), 1);
      if (intrude) begin
         wr_en = 1'b1; wr_addr = 1; wr_data = 16'hDEAD; start = 1'b1; // R5
      end
      cyc = 0;
      while (!done && cyc < 50) begin
         @(negedge clk); cyc++;
         wr_en = 1'b0; start = 1'b0;
      end
      chk("R3 cycles to done", cyc, 2 * Q);
      chk("R3 busy low with done", int'(busy), 0);
      @(negedge clk);
      chk("R3 done single cycle", int'(done), 0);
   endtask

   initial begin
      #2000000;
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 done after reset", int'(done), 0);
      rd_addr = 5; #1;
      chk("R1 cell cleared", int'(rd_data), 0);
      rst_n = 1'b1;

      // R2: layout and read-back while idle
      for (int k = 0; k < N; k++) orig[k] = W'(16'h1000 + k * 7);
      load_all();
      read_all("R2 idle read-back", 1'b0);

      // R4: lettered 4x4 case
      for (int k = 0; k < N; k++) orig[k] = W'(8'h61 + k);
      load_all();
      run(1'b0);
      read_all("R4 letters transposed", 1'b1);
      rd_addr = 1; #1; chk("R4 row0 col1 is e", int'(rd_data), 8'h65);

      // R6: second run restores input
      run(1'b0);
      read_all("R6 double transpose", 1'b0);

      // R4 sweep over arithmetic patterns
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < N; k++)
            orig[k] = W'((k * (2 * p + 3) + p * 911) ^ (p << 12));
         load_all();
         run(1'b0);
         read_all("R4 pattern sweep", 1'b1);
      end

      // R5: write and start during busy are dropped
      for (int k = 0; k < N; k++) orig[k] = W'(16'hA000 | (k << 4) | k);
      load_all();
      run(1'b1);
      read_all("R5 mid-run write ignored", 1'b1);
      chk("R5 no restart", int'(busy), 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule